// File: doc/BRIEF.md
# Rotating-Start Compacting Issue Queue Controller

This block keeps track of occupancy and compaction for a small issue queue. It is built so that entries wear evenly. Instructions enter at the tail. When an instruction issues it leaves a hole. A fully compacting queue would close that hole by shifting every younger entry down toward a fixed bottom slot, so the low slots would be rewritten far more often than the high ones. This controller compacts only the part of the queue that starts at a rotating start pointer and runs up to the tail. Entries below that pointer are never shifted. A hole there stays in place until the tail trims it off or the pointer wraps past it.

Each cycle a per-entry shift-enable vector is formed. An entry's bit is set when the entry lies inside the window from the start pointer up to the tail and a hole exists at or below it within that window. Every enabled entry copies its upper neighbour, so holes close by one position per cycle. The start pointer steps forward by one after a programmable number of cycles. For selection, the first valid entry found scanning upward from the start pointer, with wrap-around, is reported as the oldest. Each entry also has a saturating count of the shift writes it has received, so that wear can be observed.

Top module: `rr_collapse_iq`

## Requirements
- R1: After reset no entry is valid, the used count is 0, the start pointer is 0, full and stall are low, and every wear count is 0.
- R2: An accepted allocation writes its payload into position `used` (taken after that cycle's shrink), and that entry reads valid one cycle later. `entry_data` holds position i in bits [i*DW +: DW].
- R3: `full` is high when `used` equals DEPTH. An allocation request while full raises `stall` in the same cycle and changes no entry. `used` never exceeds DEPTH.
- R4: A set bit i of `issue_clr` empties position i in the same update, and that hole takes part in that cycle's compaction.
- R5: When a hole exists in the window from the start pointer to `used`-1, every entry of the window at or above the lowest such hole takes the contents of the next higher position. `used` then drops by one, so holes close one position per cycle.
- R6: Entries below the start pointer are never shifted. A valid entry there that is not cleared keeps its payload, and its wear count does not change.
- R7: When position `used`-1 is empty and no hole lies in the window, `used` drops by one with no shift write.
- R8: With `rot_period` = P > 0, the start pointer advances by one, modulo DEPTH, on every P-th cycle. The counting starts from the first cycle that sees P. With P = 0 the pointer holds.
- R9: `oldest_idx` is the first valid position found scanning upward from the start pointer and wrapping past DEPTH-1 to 0. `oldest_vld` is low when the queue holds no valid entry.
- R10: Each entry's wear count rises by one on every cycle its shift enable is set. It saturates at its maximum value. `wear_cnt` holds entry i in bits [i*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request to insert an instruction at the tail |
| alloc_data | input | DW | Payload of the inserted instruction |
| issue_clr | input | DEPTH | One bit per position; set bits empty that position |
| rot_period | input | PW | Cycles between start-pointer steps (0 holds it) |
| entry_vld | output | DEPTH | Valid bit of each position |
| entry_data | output | DEPTH*DW | Payload of each position, flattened |
| used | output | $clog2(DEPTH+1) | Tail position: count of positions in use, holes included |
| full | output | 1 | All positions in use |
| stall | output | 1 | Allocation refused this cycle |
| phead | output | $clog2(DEPTH) | Rotating start pointer |
| oldest_vld | output | 1 | At least one valid entry exists |
| oldest_idx | output | $clog2(DEPTH) | Oldest valid position in rotated order |
| wear_cnt | output | DEPTH*CW | Saturating shift-write count per entry, flattened |

## Verification
The embedded properties check on every cycle that nothing is valid above the tail and that the tail stays within bounds. They also check that a refused allocation never grows the queue, that a compaction without allocation shrinks the tail by exactly one, that the start pointer only ever takes single wrapping steps and holds at period 0, that untouched entries below the pointer keep their payload, and that wear counts stay saturated. Only the bench scenarios can show where each payload ends up after a given sequence of clears. They also show the exact cycle at which the pointer steps, the oldest index wrapping past the top of the queue, trimming of holes left below the pointer, and the per-entry wear totals after long churn.

// File: rtl/rr_collapse_iq.sv
module rr_collapse_iq #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int PW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_req,
  input  logic [DW-1:0]             alloc_data,
  input  logic [DEPTH-1:0]          issue_clr,
  input  logic [PW-1:0]             rot_period,
  output logic [DEPTH-1:0]          entry_vld,
  output logic [DEPTH*DW-1:0]       entry_data,
  output logic [$clog2(DEPTH+1)-1:0] used,
  output logic                      full,
  output logic                      stall,
  output logic [$clog2(DEPTH)-1:0]  phead,
  output logic                      oldest_vld,
  output logic [$clog2(DEPTH)-1:0]  oldest_idx,
  output logic [DEPTH*CW-1:0]       wear_cnt
);
  localparam int IW = $clog2(DEPTH);
  localparam int TW = $clog2(DEPTH+1);

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    data_q [DEPTH];
  logic [CW-1:0]    wear_q [DEPTH];
  logic [TW-1:0]    tail_q;
  logic [IW-1:0]    ph_q;
  logic [PW-1:0]    cnt_q;

  logic [DEPTH-1:0] eff, ctrl;
  logic             top_empty, shrink, accept;
  logic [TW-1:0]    base;

  assign eff = vld_q & ~issue_clr;

  always_comb begin
    logic seen;
    seen = 1'b0;
    ctrl = '0;
    top_empty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (IW'(i) >= ph_q && TW'(i) < tail_q) begin
        if (!eff[i]) seen = 1'b1;
        ctrl[i] = seen;
      end
      if (TW'(i + 1) == tail_q && !eff[i]) top_empty = 1'b1;
    end
  end

  assign shrink = (|ctrl) || top_empty;
  assign base   = tail_q - TW'(shrink);
  assign full   = tail_q == TW'(DEPTH);
  assign stall  = alloc_req && full;
  assign accept = alloc_req && !full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          up_v;
    logic [DW-1:0] up_d;
    if (i == DEPTH - 1) begin : g_top
      assign up_v = 1'b0;
      assign up_d = '0;
    end else begin : g_mid
      assign up_v = eff[i+1];
      assign up_d = data_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        data_q[i] <= '0;
        wear_q[i] <= '0;
      end else begin
        if (accept && base == TW'(i)) begin
          vld_q[i]  <= 1'b1;
          data_q[i] <= alloc_data;
        end else if (ctrl[i]) begin
          vld_q[i]  <= up_v;
          data_q[i] <= up_d;
        end else begin
          vld_q[i]  <= eff[i];
        end
        if (ctrl[i] && wear_q[i] != '1) wear_q[i] <= wear_q[i] + 1'b1;
      end
    end

    assign entry_data[i*DW +: DW] = data_q[i];
    assign wear_cnt[i*CW +: CW]   = wear_q[i];

    p_wear_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wear_q[i] == '1) |=> (wear_q[i] == '1));

    p_below_ph_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (IW'(i) < ph_q && vld_q[i] && !issue_clr[i]) |=> (vld_q[i] && $stable(data_q[i])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else begin
      tail_q <= base + TW'(accept);
      if (rot_period == '0) begin
        cnt_q <= '0;
      end else if (cnt_q >= rot_period - 1'b1) begin
        cnt_q <= '0;
        ph_q  <= (ph_q == IW'(DEPTH - 1)) ? '0 : ph_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_vld = 1'b0;
    oldest_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int p;
      p = int'(ph_q) + k;
      if (p >= DEPTH) p = p - DEPTH;
      if (vld_q[p]) begin
        oldest_vld = 1'b1;
        oldest_idx = IW'(p);
      end
    end
  end

  assign entry_vld = vld_q;
  assign used      = tail_q;
  assign phead     = ph_q;

  function automatic logic [IW-1:0] ph_inc(input logic [IW-1:0] v);
    return (v == IW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q <= TW'(DEPTH));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (tail_q <= $past(tail_q)));

  p_empty_above_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_q >> tail_q) == '0));

  p_shift_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ctrl) && !alloc_req) |=> (tail_q == $past(tail_q) - 1'b1));

  p_ph_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> (ph_q == ph_inc($past(ph_q))));

  p_ph_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_period == '0) |=> $stable(ph_q));

  p_oldest_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_vld |-> vld_q[oldest_idx]);
endmodule

// File: tb/sim_rr_collapse_iq.sv
`timescale 1ns/1ps
module sim_rr_collapse_iq;
  localparam int DEPTH = 8, DW = 8, CW = 8, PW = 8;
  localparam int K_VLD = 0, K_USED = 1, K_PH = 2, K_DATA = 3, K_WEAR = 4,
                 K_FULL = 5, K_OLD = 6, K_OLDV = 7;

  logic clk = 0, rst_n = 0, alloc_req = 0;
  logic [DW-1:0] alloc_data = '0;
  logic [DEPTH-1:0] issue_clr = '0;
  logic [PW-1:0] rot_period = '0;
  logic [DEPTH-1:0] entry_vld;
  logic [DEPTH*DW-1:0] entry_data;
  logic [3:0] used;
  logic full, stall, oldest_vld;
  logic [2:0] phead, oldest_idx;
  logic [DEPTH*CW-1:0] wear_cnt;

  rr_collapse_iq #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_data(alloc_data),
    .issue_clr(issue_clr), .rot_period(rot_period), .entry_vld(entry_vld),
    .entry_data(entry_data), .used(used), .full(full), .stall(stall),
    .phead(phead), .oldest_vld(oldest_vld), .oldest_idx(oldest_idx),
    .wear_cnt(wear_cnt));

  always #2 clk = ~clk;

  typedef struct { int at; int kind; int idx; int val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0, rp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_nx(int kind, int idx, int val, string req);
    exp_t e;
    e.at = cyc + 1; e.kind = kind; e.idx = idx; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic drive(logic req, logic [DW-1:0] d, logic [DEPTH-1:0] clr);
    @(negedge clk);
    alloc_req = req; alloc_data = d; issue_clr = clr; rot_period = PW'(rp);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      int act;
      e = q.pop_front();
      case (e.kind)
        K_VLD:  act = int'(entry_vld);
        K_USED: act = int'(used);
        K_PH:   act = int'(phead);
        K_DATA: act = int'(entry_data[e.idx*DW +: DW]);
        K_WEAR: act = int'(wear_cnt[e.idx*CW +: CW]);
        K_FULL: act = int'(full);
        K_OLD:  act = int'(oldest_idx);
        default: act = int'(oldest_vld);
      endcase
      chk(e.req, act, e.val);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 vld", int'(entry_vld), 0);
    chk("R1 used", int'(used), 0);
    chk("R1 ph", int'(phead), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 stall", int'(stall), 0);
    chk("R1 wear", int'(wear_cnt), 0);

    // R2 fill
    for (int i = 0; i < DEPTH; i++) begin
      drive(1, DW'(10 + i), '0);
      #1 if (i == 0) chk("R3 no stall", int'(stall), 0);
    end
    expect_nx(K_USED, 0, 8, "R3 used full");
    expect_nx(K_FULL, 0, 1, "R3 full");
    expect_nx(K_VLD, 0, 8'hff, "R2 vld");
    expect_nx(K_DATA, 3, 13, "R2 data3");
    expect_nx(K_DATA, 7, 17, "R2 data7");
    // R3 stall when full
    drive(1, 8'd99, '0);
    #1 chk("R3 stall", int'(stall), 1);
    expect_nx(K_USED, 0, 8, "R3 used held");
    expect_nx(K_DATA, 7, 17, "R3 data held");

    // R4/R5 single hole at 2
    drive(0, 0, 8'h04);
    expect_nx(K_VLD, 0, 8'h7f, "R4 vld");
    expect_nx(K_USED, 0, 7, "R5 used");
    expect_nx(K_DATA, 2, 13, "R5 data2");
    expect_nx(K_DATA, 6, 17, "R5 data6");
    expect_nx(K_FULL, 0, 0, "R3 not full");
    expect_nx(K_WEAR, 1, 0, "R10 wear1");
    expect_nx(K_WEAR, 2, 1, "R10 wear2");
    expect_nx(K_WEAR, 7, 1, "R10 wear7");
    // two holes at 1 and 4
    drive(0, 0, 8'h12);
    expect_nx(K_VLD, 0, 8'h37, "R5 vld two holes");
    expect_nx(K_USED, 0, 6, "R5 used 6");
    expect_nx(K_DATA, 1, 13, "R5 data1");
    drive(0, 0, '0);
    expect_nx(K_VLD, 0, 8'h1f, "R5 second step vld");
    expect_nx(K_USED, 0, 5, "R5 used 5");
    expect_nx(K_DATA, 3, 16, "R5 data3");
    expect_nx(K_WEAR, 3, 3, "R10 wear3");
    expect_nx(K_WEAR, 2, 2, "R10 wear2 again");
    drive(0, 0, '0);
    expect_nx(K_USED, 0, 5, "R5 settled");

    // R8 rotation with period 3
    rp = 3;
    for (int d = 1; d <= 6; d++) begin
      drive(0, 0, '0);
      if (d == 2) expect_nx(K_PH, 0, 0, "R8 not yet");
      if (d == 3) expect_nx(K_PH, 0, 1, "R8 step1");
      if (d == 6) begin
        expect_nx(K_PH, 0, 2, "R8 step2");
        expect_nx(K_OLD, 0, 2, "R9 oldest at ph");
      end
    end
    rp = 0;
    drive(0, 0, '0);
    expect_nx(K_PH, 0, 2, "R8 hold at 0");

    // R6 holes below ph stay
    drive(0, 0, 8'h09);
    expect_nx(K_VLD, 0, 8'h0e, "R6 vld");
    expect_nx(K_USED, 0, 4, "R6 used");
    expect_nx(K_DATA, 1, 13, "R6 data1 kept");
    expect_nx(K_DATA, 3, 17, "R5 data3 shift");
    expect_nx(K_WEAR, 1, 1, "R6 wear1 kept");
    drive(0, 0, '0);
    expect_nx(K_VLD, 0, 8'h0e, "R6 hole persists");
    expect_nx(K_USED, 0, 4, "R6 used kept");

    // R9 wrap
    drive(0, 0, 8'h0c);
    expect_nx(K_VLD, 0, 8'h02, "R5 vld after clr");
    expect_nx(K_USED, 0, 3, "R5 used 3");
    drive(0, 0, '0);
    expect_nx(K_USED, 0, 2, "R5 used 2");
    drive(0, 0, '0);
    expect_nx(K_USED, 0, 2, "R7 used stays");
    expect_nx(K_OLD, 0, 1, "R9 wrap oldest");
    expect_nx(K_OLDV, 0, 1, "R9 oldest vld");

    // R7 trim
    drive(0, 0, 8'h02);
    expect_nx(K_USED, 0, 1, "R7 trim1");
    expect_nx(K_VLD, 0, 0, "R4 empty");
    expect_nx(K_WEAR, 1, 1, "R7 no shift write");
    drive(0, 0, '0);
    expect_nx(K_USED, 0, 0, "R7 trim2");
    expect_nx(K_OLDV, 0, 0, "R9 none valid");

    // R2 refill and alloc with same-cycle shrink
    for (int i = 0; i < 4; i++) drive(1, DW'(8'h55 + i), '0);
    expect_nx(K_USED, 0, 4, "R2 used 4");
    expect_nx(K_DATA, 0, 8'h55, "R2 data0");
    expect_nx(K_DATA, 3, 8'h58, "R2 data3");
    drive(1, 8'h59, 8'h04);
    expect_nx(K_DATA, 2, 8'h58, "R5 data2 shift");
    expect_nx(K_DATA, 3, 8'h59, "R2 data at shrunk tail");
    expect_nx(K_USED, 0, 4, "R2 used after churn");
    expect_nx(K_VLD, 0, 8'h0f, "R2 vld");

    // R10 saturation under churn
    for (int i = 0; i < 300; i++) drive(1, DW'(i), 8'h04);
    drive(0, 0, '0);
    expect_nx(K_WEAR, 2, 255, "R10 sat2");
    expect_nx(K_WEAR, 3, 255, "R10 sat3");
    expect_nx(K_WEAR, 0, 0, "R6 wear0 untouched");
    expect_nx(K_USED, 0, 4, "R2 used final");
    expect_nx(K_DATA, 3, 43, "R2 last payload");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule